// File: doc/BRIEF.md
# Regulator protection and power-good supervisor

This block is the digital supervisor of a two-phase step-down regulator controller. It reads digital flags from the analog front end: the supply-above-undervoltage flag, the enable input, the soft-start-complete flag, per-phase overcurrent and zero-current flags, the overvoltage flag, the over-temperature flags (hot and cooled) and the output-below-power-good flag. It also reads the 5-bit voltage code. From these it decides whether the gate sequencer may switch, whether both low sides must be held on, when a new soft start begins, and whether power is good.

A six-state machine (off, soft start, run, overcurrent recovery, overvoltage latch, over-temperature wait) applies a fixed fault priority. An overcurrent holds the low sides on until every phase reports zero current and then restarts soft start. An overvoltage latches until the supply flag falls. Over-temperature stops switching until the cooled flag is seen. The power-good flag rises as soon as the output is in range, but it falls only after the low condition has been seen for a long, counted qualification window.

Top module: `rsup_top`

## Requirements
- R1: While `uvlo_ok` is low, one clock edge later `run` and `force_low` are 0 and the machine is in its off state. After reset `run`, `force_low`, `ss_restart` and `pgood` are all 0.
- R2: From the off state, with `uvlo_ok` and `enable` high and a code other than 11111, the next edge sets `run` to 1, and `ss_restart` is 1 for exactly that one cycle.
- R3: `pgood` stays 0 during soft start. One edge after `ss_done` is sampled, the machine is in run. One further edge with `below_pg` low sets `pgood` to 1, with no delay.
- R4: In soft start or run, `oc` high in any phase sets `force_low`=1 and `run`=0 on the next edge. This holds until `zc` is high for every phase. The edge that samples all-zero current sets `run`=1, `force_low`=0 and `ss_restart`=1.
- R5: `ov` high while `uvlo_ok` is high sets `force_low`=1 and `run`=0 on the next edge. The latch then holds whatever `ov`, `enable` or the temperature flags do, and only `uvlo_ok` going low releases it. A restart needs `uvlo_ok` to return high.
- R6: `ot_hot` sets `run`=0 and `force_low`=0 on the next edge, and both stay 0 until `ot_clear` is sampled. That edge returns the machine to off, and the following edge restarts soft start if the block is enabled.
- R7: `enable` low sets `run`=0 and `force_low`=0 on the next edge. `pgood` is 0 one edge later and stays 0 while disabled. Power good may be high only in run or in overcurrent recovery.
- R8: While `pgood` is high in run or recovery, it falls on the PG_DLY_CYC-th consecutive edge that samples `below_pg` high. Any edge that samples it low restarts the count.
- R9: `out_off` is 1 combinationally exactly for code 11111. That code acts like a disable: no start from off, and switching stops on the next edge.
- R10: When several conditions are sampled in the same cycle, they take effect in this order: `uvlo_ok` low, then `ov`, then `ot_hot`, then disable or off code, then `oc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| uvlo_ok | input | 1 | Supply above undervoltage threshold |
| enable | input | 1 | Output enable |
| ss_done | input | 1 | Soft-start ramp complete |
| oc | input | NPH | Overcurrent flag per phase |
| zc | input | NPH | Zero-current flag per phase |
| ov | input | 1 | Output overvoltage |
| ot_hot | input | 1 | Die over-temperature |
| ot_clear | input | 1 | Die has cooled enough to resume |
| below_pg | input | 1 | Output below power-good threshold |
| vcode | input | VID_W | Voltage setpoint code |
| run | output | 1 | Switching permitted to gate sequencer |
| force_low | output | 1 | Hold low sides on, high sides off |
| ss_restart | output | 1 | One-cycle pulse starting a soft start |
| out_off | output | 1 | Code selects output off |
| pgood | output | 1 | Active-high power good |

## Verification
Two collisions are provoked on purpose. In the first, an overvoltage and a phase overcurrent are raised on the same edge during run. The outputs must show the latch (low sides held) rather than recovery, and clearing the overcurrent, dropping `enable` or raising `ot_hot` must leave the latch in place until the supply flag cycles. In the second, the same edge samples over-temperature and an overcurrent. The result must be both drives off, not low sides on. The power-good qualification window is also crossed with overcurrent recovery, to show that the flag stays high through a short recovery.

// File: rtl/rsup_pkg.sv
package rsup_pkg;

    typedef enum logic [2:0] {
        ST_OFF        = 3'd0,
        ST_SOFTSTART  = 3'd1,
        ST_RUN        = 3'd2,
        ST_OC_RECOVER = 3'd3,
        ST_OV_LATCH   = 3'd4,
        ST_OT_WAIT    = 3'd5
    } sup_state_e;

    typedef struct packed {
        logic uvlo_ok;
        logic enable;
        logic ss_done;
        logic oc_any;
        logic zc_all;
        logic ov;
        logic ot_hot;
        logic ot_clear;
        logic code_off;
    } sup_flags_t;

    function automatic logic pg_allowed(input sup_state_e s);
        return (s == ST_RUN) || (s == ST_OC_RECOVER);
    endfunction

    function automatic logic is_switching(input sup_state_e s);
        return (s == ST_SOFTSTART) || (s == ST_RUN);
    endfunction

    function automatic logic is_low_forced(input sup_state_e s);
        return (s == ST_OC_RECOVER) || (s == ST_OV_LATCH);
    endfunction

endpackage

// File: rtl/rsup_vcode.sv
module rsup_vcode #(
    parameter int VID_W = 5
) (
    input  logic [VID_W-1:0] code,
    output logic             code_off
);
    localparam logic [VID_W-1:0] OFF_CODE = {VID_W{1'b1}};

    always_comb code_off = (code == OFF_CODE);
endmodule

// File: rtl/rsup_phase_merge.sv
module rsup_phase_merge #(
    parameter int NPH = 2
) (
    input  logic [NPH-1:0] oc,
    input  logic [NPH-1:0] zc,
    output logic           oc_any,
    output logic           zc_all
);
    logic [NPH:0] oc_chain;
    logic [NPH:0] zc_chain;

    assign oc_chain[0] = 1'b0;
    assign zc_chain[0] = 1'b1;

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        assign oc_chain[p+1] = oc_chain[p] | oc[p];
        assign zc_chain[p+1] = zc_chain[p] & zc[p];
    end

    assign oc_any = oc_chain[NPH];
    assign zc_all = zc_chain[NPH];
endmodule

// File: rtl/rsup_fsm.sv
module rsup_fsm
    import rsup_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  sup_flags_t fl,
    output sup_state_e state_q,
    output logic       ss_restart
);
    sup_state_e state_d;
    logic       go_ok;

    always_comb begin
        go_ok   = fl.enable && !fl.code_off;
        state_d = state_q;
        if (!fl.uvlo_ok) begin
            state_d = ST_OFF;
        end else if (state_q == ST_OV_LATCH || fl.ov) begin
            state_d = ST_OV_LATCH;
        end else if (state_q == ST_OT_WAIT) begin
            if (fl.ot_clear) state_d = ST_OFF;
        end else if (fl.ot_hot) begin
            state_d = ST_OT_WAIT;
        end else if (!go_ok) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:        state_d = ST_SOFTSTART;
                ST_SOFTSTART:  begin
                    if (fl.oc_any)       state_d = ST_OC_RECOVER;
                    else if (fl.ss_done) state_d = ST_RUN;
                end
                ST_RUN:        if (fl.oc_any) state_d = ST_OC_RECOVER;
                ST_OC_RECOVER: if (fl.zc_all) state_d = ST_SOFTSTART;
                default:       state_d = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_OFF;
            ss_restart <= 1'b0;
        end else begin
            state_q    <= state_d;
            ss_restart <= (state_d == ST_SOFTSTART) && (state_q != ST_SOFTSTART);
        end
    end
endmodule

// File: rtl/rsup_pgood.sv
module rsup_pgood #(
    parameter int PG_DLY_CYC = 50000
) (
    input  logic clk,
    input  logic rst,
    input  logic allow,
    input  logic below,
    output logic pgood
);
    localparam int CNT_W = $clog2(PG_DLY_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PG_DLY_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !allow) begin
            pgood <= 1'b0;
            cnt_q <= '0;
        end else if (!below) begin
            pgood <= 1'b1;
            cnt_q <= '0;
        end else if (pgood) begin
            if (cnt_q == LAST) begin
                pgood <= 1'b0;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rsup_top.sv
module rsup_top
    import rsup_pkg::*;
#(
    parameter int NPH        = 2,
    parameter int VID_W      = 5,
    parameter int PG_DLY_CYC = 50000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             uvlo_ok,
    input  logic             enable,
    input  logic             ss_done,
    input  logic [NPH-1:0]   oc,
    input  logic [NPH-1:0]   zc,
    input  logic             ov,
    input  logic             ot_hot,
    input  logic             ot_clear,
    input  logic             below_pg,
    input  logic [VID_W-1:0] vcode,
    output logic             run,
    output logic             force_low,
    output logic             ss_restart,
    output logic             out_off,
    output logic             pgood
);
    sup_flags_t fl;
    sup_state_e state_q;
    logic       oc_any;
    logic       zc_all;
    logic       code_off;

    rsup_vcode #(.VID_W(VID_W)) vcode_i (
        .code     (vcode),
        .code_off (code_off)
    );

    rsup_phase_merge #(.NPH(NPH)) merge_i (
        .oc     (oc),
        .zc     (zc),
        .oc_any (oc_any),
        .zc_all (zc_all)
    );

    always_comb begin
        fl.uvlo_ok  = uvlo_ok;
        fl.enable   = enable;
        fl.ss_done  = ss_done;
        fl.oc_any   = oc_any;
        fl.zc_all   = zc_all;
        fl.ov       = ov;
        fl.ot_hot   = ot_hot;
        fl.ot_clear = ot_clear;
        fl.code_off = code_off;
    end

    rsup_fsm fsm_i (
        .clk        (clk),
        .rst        (rst),
        .fl         (fl),
        .state_q    (state_q),
        .ss_restart (ss_restart)
    );

    rsup_pgood #(.PG_DLY_CYC(PG_DLY_CYC)) pg_i (
        .clk   (clk),
        .rst   (rst),
        .allow (pg_allowed(state_q)),
        .below (below_pg),
        .pgood (pgood)
    );

    assign run       = is_switching(state_q);
    assign force_low = is_low_forced(state_q);
    assign out_off   = code_off;
endmodule

// File: rtl/rsup_chk.sv
module rsup_chk
    import rsup_pkg::*;
#(
    parameter int NPH        = 2,
    parameter int PG_DLY_CYC = 50000
) (
    input logic           clk,
    input logic           rst,
    input logic           uvlo_ok,
    input logic           enable,
    input logic [NPH-1:0] oc,
    input logic           ov,
    input logic           ot_hot,
    input logic           ot_clear,
    input logic           below_pg,
    input logic           out_off,
    input logic           run,
    input logic           force_low,
    input logic           ss_restart,
    input logic           pgood,
    input sup_state_e     state_q
);
    int unsigned low_cnt;

    always_ff @(posedge clk) begin
        if (rst || !pg_allowed(state_q) || !below_pg || !pgood) low_cnt <= 0;
        else low_cnt <= low_cnt + 1;
    end

    assert_uvlo_off_R1: assert property (@(posedge clk) disable iff (rst)
        !uvlo_ok |=> (!run && !force_low));

    assert_restart_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        ss_restart |=> !ss_restart);

    assert_pg_rise_R3: assert property (@(posedge clk) disable iff (rst)
        (pg_allowed(state_q) && !below_pg) |=> pgood);

    assert_oc_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (run && (|oc) && uvlo_ok && !ov && !ot_hot && enable && !out_off)
        |=> (force_low && !run));

    assert_ov_latch_R5: assert property (@(posedge clk) disable iff (rst)
        (ov && uvlo_ok) |=> (force_low && !run));

    assert_ov_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_OV_LATCH && uvlo_ok) |=> (state_q == ST_OV_LATCH));

    assert_ot_stop_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_OT_WAIT && uvlo_ok && !ov && !ot_clear) |=> (!run && !force_low));

    assert_pg_forced_R7: assert property (@(posedge clk) disable iff (rst)
        !pg_allowed(state_q) |=> !pgood);

    assert_pg_delay_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(pgood) |-> ($past(!pg_allowed(state_q)) || $past(low_cnt) == PG_DLY_CYC - 1));
endmodule

bind rsup_top rsup_chk #(.NPH(NPH), .PG_DLY_CYC(PG_DLY_CYC)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .uvlo_ok    (uvlo_ok),
    .enable     (enable),
    .oc         (oc),
    .ov         (ov),
    .ot_hot     (ot_hot),
    .ot_clear   (ot_clear),
    .below_pg   (below_pg),
    .out_off    (out_off),
    .run        (run),
    .force_low  (force_low),
    .ss_restart (ss_restart),
    .pgood      (pgood),
    .state_q    (state_q)
);

// File: tb/rsup_tb_top.sv
module rsup_tb_top;
    localparam int NPH = 2;
    localparam int VW  = 5;
    localparam int DLY = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic uvlo_ok = 1'b0, enable = 1'b0, ss_done = 1'b0;
    logic [NPH-1:0] oc = '0, zc = '0;
    logic ov = 1'b0, ot_hot = 1'b0, ot_clear = 1'b0, below_pg = 1'b0;
    logic [VW-1:0] vcode = 5'b01111;
    logic run, force_low, ss_restart, out_off, pgood;

    int errors = 0;
    int total  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    rsup_top #(.NPH(NPH), .VID_W(VW), .PG_DLY_CYC(DLY)) dut_i (
        .clk(clk), .rst(rst), .uvlo_ok(uvlo_ok), .enable(enable), .ss_done(ss_done),
        .oc(oc), .zc(zc), .ov(ov), .ot_hot(ot_hot), .ot_clear(ot_clear),
        .below_pg(below_pg), .vcode(vcode), .run(run), .force_low(force_low),
        .ss_restart(ss_restart), .out_off(out_off), .pgood(pgood)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // from soft start: one edge into run, one more edge for power good
    task automatic go_run();
        ss_done = 1'b1;
        tick();
        ss_done = 1'b0;
        chk("R3 pg low entering run", pgood, 0);
        tick();
        chk("R3 pg rises in run", pgood, 1);
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        chk("R1 reset run", run, 0);
        chk("R1 reset force_low", force_low, 0);
        chk("R1 reset ss_restart", ss_restart, 0);
        chk("R1 reset pgood", pgood, 0);

        enable = 1'b1;
        tick();
        chk("R1 no start without uvlo", run, 0);

        uvlo_ok = 1'b1;
        tick();
        chk("R2 start run", run, 1);
        chk("R2 start pulse", ss_restart, 1);
        tick();
        chk("R2 pulse one cycle", ss_restart, 0);
        chk("R3 pg low in soft start", pgood, 0);
        go_run();

        // R8 sweep: gaps shorter than the window keep power good
        for (int g = 1; g < DLY; g++) begin
            below_pg = 1'b1;
            for (int k = 0; k < g; k++) begin
                tick();
                chk("R8 pg held during short low", pgood, 1);
            end
            below_pg = 1'b0;
            tick();
            chk("R8 pg after gap", pgood, 1);
        end
        below_pg = 1'b1;
        for (int k = 1; k <= DLY + 2; k++) begin
            tick();
            chk("R8 pg qualified fall", pgood, (k < DLY) ? 1 : 0);
        end
        below_pg = 1'b0;
        tick();
        chk("R3 pg reasserts at once", pgood, 1);

        // R4 per phase overcurrent recovery
        for (int p = 0; p < NPH; p++) begin
            oc = '0;
            oc[p] = 1'b1;
            tick();
            oc = '0;
            chk("R4 force_low on oc", force_low, 1);
            chk("R4 run off on oc", run, 0);
            chk("R8 pg kept in recovery", pgood, 1);
            zc = '0;
            zc[p] = 1'b1;
            tick();
            chk("R4 held until all phases zero", force_low, 1);
            zc = '1;
            tick();
            zc = '0;
            chk("R4 restart run", run, 1);
            chk("R4 restart force_low", force_low, 0);
            chk("R4 restart pulse", ss_restart, 1);
            tick();
            chk("R7 pg low in soft start after oc", pgood, 0);
            go_run();
        end

        // R10 ov and oc together; R5 latch
        ov = 1'b1;
        oc = 2'b01;
        tick();
        chk("R10 ov beats oc force_low", force_low, 1);
        chk("R10 ov beats oc run", run, 0);
        ov = 1'b0;
        oc = '0;
        zc = '1;
        tick();
        chk("R5 latch ignores zero current", force_low, 1);
        chk("R5 pg low in latch", pgood, 0);
        zc = '0;
        enable = 1'b0;
        ot_hot = 1'b1;
        tick();
        chk("R5 latch ignores disable and ot", force_low, 1);
        enable = 1'b1;
        ot_hot = 1'b0;
        tick();
        chk("R5 latch holds on enable", force_low, 1);
        chk("R5 no restart while latched", run, 0);
        uvlo_ok = 1'b0;
        tick();
        chk("R1 uvlo drop clears latch", force_low, 0);
        chk("R1 uvlo drop run", run, 0);
        uvlo_ok = 1'b1;
        tick();
        chk("R5 restart after supply cycle", run, 1);
        chk("R5 restart pulse", ss_restart, 1);
        go_run();

        // R10 ot beats oc; R6 wait
        ot_hot = 1'b1;
        oc = 2'b10;
        tick();
        chk("R10 ot beats oc force_low", force_low, 0);
        chk("R6 ot stops run", run, 0);
        ot_hot = 1'b0;
        oc = '0;
        repeat (3) begin
            tick();
            chk("R6 waits for clear", run, 0);
        end
        ot_clear = 1'b1;
        tick();
        ot_clear = 1'b0;
        chk("R6 clear goes off first", run, 0);
        tick();
        chk("R6 resume run", run, 1);
        chk("R6 resume pulse", ss_restart, 1);
        go_run();

        // R7 disable; R10 disable beats oc
        enable = 1'b0;
        oc = 2'b11;
        tick();
        chk("R7 disable run", run, 0);
        chk("R10 disable beats oc", force_low, 0);
        oc = '0;
        tick();
        chk("R7 pg low when disabled", pgood, 0);
        tick();
        chk("R7 stays off", run, 0);

        // R9 code sweep
        for (int c = 0; c < 32; c++) begin
            vcode = VW'(c);
            #1;
            chk("R9 out_off decode", out_off, (c == 31) ? 1 : 0);
        end
        enable = 1'b1;
        tick();
        chk("R9 off code blocks start", run, 0);
        vcode = 5'b00000;
        tick();
        chk("R9 start after valid code", run, 1);
        go_run();
        vcode = 5'b11111;
        tick();
        chk("R9 off code stops run", run, 0);
        chk("R9 off code no force_low", force_low, 0);

        // R10 uvlo beats ov
        vcode = 5'b10000;
        tick();
        uvlo_ok = 1'b0;
        ov = 1'b1;
        tick();
        chk("R10 uvlo beats ov", force_low, 0);
        ov = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, total);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            total++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, total);
            $finish;
        end
    end
endmodule